// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor

This block is a small 8-bit processor that completes every instruction in one clock. Its architectural state is a 4-bit program counter, an 8-bit accumulator, one 8-bit general register and a one-bit zero flag. It has two 16-byte memories, one for program and one for data, and both are addressed only directly. Each instruction byte holds an operation code and a 4-bit address. A purely combinational control unit turns the operation code, through a one-hot 4-to-16 decode, into register load enables, multiplexer selects, the ALU operation and the data-memory write strobe.

Before a run, both memories are filled through a byte-wide preload port while the core is held in reset. Once reset is released, the core fetches from address 0. The accumulator, the program counter and the data-memory write transaction (address, data, strobe) appear on output ports, so a program's progress can be followed cycle by cycle from outside.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and during the two clocks of synchronous release, pc_o and ac_o read 0 and dm_we_o is low. The general register and the zero flag also clear to 0.
- R2: An instruction byte carries the operation code in bits [7:4] and an address in bits [3:0]. The codes are 0 NOP, 1 LDAC, 2 STAC, 3 MVAC, 4 MOVR, 5 JUMP, 6 JMPZ, 7 JMPNZ, 8 ADD, 9 SUB, A INAC, B CLAC, C AND, D OR, E XOR, F NOT.
- R3: ADD, SUB, AND, OR and XOR combine the accumulator with the general register and write the 8-bit result to the accumulator. SUB computes accumulator minus register modulo 256.
- R4: INAC adds one to the accumulator (255 becomes 0), NOT inverts every accumulator bit, and CLAC writes 0 to the accumulator.
- R5: LDAC loads the accumulator from the data-memory byte at the address field. During a STAC cycle dm_we_o is high, dm_addr_o carries the address field and dm_wdata_o carries the accumulator, and the byte is stored at the next rising edge. dm_we_o is low for every other code.
- R6: MVAC copies the accumulator into the general register and leaves the accumulator unchanged. MOVR copies the general register into the accumulator.
- R7: JUMP always loads the address field into the program counter. JMPZ loads it only when the zero flag is 1, and JMPNZ loads it only when the zero flag is 0. A branch that is not taken advances the program counter by one.
- R8: The zero flag takes the value (new accumulator == 0) on every instruction that writes the accumulator (LDAC, MOVR, ADD, SUB, INAC, CLAC, AND, OR, XOR, NOT). It holds its value through all other instructions.
- R9: Every non-branch instruction advances the program counter by one, and 15 wraps to 0.
- R10: NOP leaves the accumulator, the register, the flag and data memory unchanged and only advances the program counter.
- R11: While load_en is high, load_data is written at the rising edge into program memory (load_imem=1) or data memory (load_imem=0) at load_addr.
- R12: With data byte 0 preloaded to 55, the program LDAC 0, INAC, JMPNZ 4, JUMP 0, INAC, MVAC, ADD, STAC 2, NOP performs its store from program address 7 with address 2 and data 114.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_en | input | 1 | Preload write strobe |
| load_imem | input | 1 | Preload target: 1 program memory, 0 data memory |
| load_addr | input | 4 | Preload byte address |
| load_data | input | 8 | Preload byte |
| ac_o | output | 8 | Accumulator |
| pc_o | output | 4 | Program counter (address of the executing instruction) |
| dm_addr_o | output | 4 | Address field of the current instruction |
| dm_wdata_o | output | 8 | Data presented for a store (the accumulator) |
| dm_we_o | output | 1 | Data-memory write strobe, high during STAC |

## Verification
Three programs run against a behavioural model that is compared on every clock. The loop program, with its terminating preload, separates correct conditional branching and the flag from a machine that never leaves the loop or stores the wrong sum. The invert-then-xor program gives an all-ones result with the flag clear, so it detects a JMPZ that fires on the wrong flag value or a NOT that is off by one bit. A third program reaches every code: it forces an INAC wrap to zero ahead of a taken JMPZ, runs SUB with a borrow, and chains AND, OR and XOR down to zero before an untaken JMPNZ. It then falls through address 15, which exposes errors in the operand order, in flag refresh and hold, and in counter wrap.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  // Fixed 16-entry operation code set.
  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_LDAC  = 4'h1,
    OP_STAC  = 4'h2,
    OP_MVAC  = 4'h3,
    OP_MOVR  = 4'h4,
    OP_JUMP  = 4'h5,
    OP_JMPZ  = 4'h6,
    OP_JMPNZ = 4'h7,
    OP_ADD   = 4'h8,
    OP_SUB   = 4'h9,
    OP_INAC  = 4'hA,
    OP_CLAC  = 4'hB,
    OP_AND   = 4'hC,
    OP_OR    = 4'hD,
    OP_XOR   = 4'hE,
    OP_NOT   = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOT, ALU_INC, ALU_ZERO
  } alu_op_e;

  typedef enum logic [1:0] {
    AC_FROM_ALU, AC_FROM_MEM, AC_FROM_REG
  } ac_src_e;

  typedef enum logic [1:0] {
    BR_NONE, BR_ALWAYS, BR_IF_Z, BR_IF_NZ
  } br_e;

  typedef struct packed {
    logic    ac_load;
    ac_src_e ac_src;
    alu_op_e alu_op;
    logic    r_load;
    logic    dm_we;
    br_e     br;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOT:  y = ~a;
      ALU_INC:  y = a + W'(1);
      ALU_ZERO: y = '0;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  opcode_e op,
  output ctrl_t   ctl
);

  localparam int NCODES = 16;

  logic [NCODES-1:0] hot;

  // One-hot 4-to-16 decode of the operation code.
  for (genvar i = 0; i < NCODES; i++) begin : g_dec
    assign hot[i] = (4'(op) == 4'(i));
  end

  always_comb begin
    ctl.ac_load = hot[OP_LDAC] | hot[OP_MOVR] | hot[OP_ADD]  | hot[OP_SUB] |
                  hot[OP_INAC] | hot[OP_CLAC] | hot[OP_AND]  | hot[OP_OR]  |
                  hot[OP_XOR]  | hot[OP_NOT];
    ctl.r_load  = hot[OP_MVAC];
    ctl.dm_we   = hot[OP_STAC];

    if (hot[OP_LDAC])      ctl.ac_src = AC_FROM_MEM;
    else if (hot[OP_MOVR]) ctl.ac_src = AC_FROM_REG;
    else                   ctl.ac_src = AC_FROM_ALU;

    if (hot[OP_SUB])       ctl.alu_op = ALU_SUB;
    else if (hot[OP_AND])  ctl.alu_op = ALU_AND;
    else if (hot[OP_OR])   ctl.alu_op = ALU_OR;
    else if (hot[OP_XOR])  ctl.alu_op = ALU_XOR;
    else if (hot[OP_NOT])  ctl.alu_op = ALU_NOT;
    else if (hot[OP_INAC]) ctl.alu_op = ALU_INC;
    else if (hot[OP_CLAC]) ctl.alu_op = ALU_ZERO;
    else                   ctl.alu_op = ALU_ADD;

    if (hot[OP_JUMP])       ctl.br = BR_ALWAYS;
    else if (hot[OP_JMPZ])  ctl.br = BR_IF_Z;
    else if (hot[OP_JMPNZ]) ctl.br = BR_IF_NZ;
    else                    ctl.br = BR_NONE;
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = acc_cpu_pkg::DATA_W,
  parameter int ADDR_W = acc_cpu_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              load_imem,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] ac_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] dm_addr_o,
  output logic [DATA_W-1:0] dm_wdata_o,
  output logic              dm_we_o
);

  localparam int OP_W = DATA_W - ADDR_W;

  // Reset release synchronizer. run_q duplicates the last stage so the
  // datapath never uses the net that drives the asynchronous clears.
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
      run_q      <= 1'b0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
      run_q      <= rst_sync_q[0];
    end
  end

  assign core_rst_n = rst_sync_q[1];

  // Architectural state.
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ac_q, ac_d;
  logic [DATA_W-1:0] r_q;
  logic              z_q, z_d;

  // Fetch and decode.
  logic [DATA_W-1:0] instr;
  logic [ADDR_W-1:0] field;
  opcode_e           op;
  ctrl_t             ctl;

  acc_cpu_ram #(.W(DATA_W), .AW(ADDR_W)) u_imem (
    .clk   (clk),
    .we    (load_en & load_imem),
    .waddr (load_addr),
    .wdata (load_data),
    .raddr (pc_q),
    .rdata (instr)
  );

  assign field = instr[ADDR_W-1:0];
  assign op    = opcode_e'(instr[DATA_W-1 -: OP_W]);

  acc_cpu_ctrl u_ctrl (
    .op  (op),
    .ctl (ctl)
  );

  // Data memory: preload port has priority, core store gated until run.
  logic              core_we;
  logic              dmem_we;
  logic [ADDR_W-1:0] dmem_waddr;
  logic [DATA_W-1:0] dmem_wdata;
  logic [DATA_W-1:0] dmem_rdata;

  assign core_we    = ctl.dm_we & run_q;
  assign dmem_we    = (load_en & ~load_imem) | core_we;
  assign dmem_waddr = load_en ? load_addr : field;
  assign dmem_wdata = load_en ? load_data : ac_q;

  acc_cpu_ram #(.W(DATA_W), .AW(ADDR_W)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (dmem_waddr),
    .wdata (dmem_wdata),
    .raddr (field),
    .rdata (dmem_rdata)
  );

  // Execute.
  logic [DATA_W-1:0] alu_y;
  logic              taken;

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .a  (ac_q),
    .b  (r_q),
    .op (ctl.alu_op),
    .y  (alu_y)
  );

  always_comb begin
    unique case (ctl.ac_src)
      AC_FROM_MEM: ac_d = dmem_rdata;
      AC_FROM_REG: ac_d = r_q;
      default:     ac_d = alu_y;
    endcase
    z_d = (ac_d == '0);

    unique case (ctl.br)
      BR_ALWAYS: taken = 1'b1;
      BR_IF_Z:   taken = z_q;
      BR_IF_NZ:  taken = ~z_q;
      default:   taken = 1'b0;
    endcase
    pc_d = taken ? field : pc_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
      ac_q <= '0;
      r_q  <= '0;
      z_q  <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (ctl.ac_load) begin
        ac_q <= ac_d;
        z_q  <= z_d;
      end
      if (ctl.r_load) r_q <= ac_q;
    end
  end

  assign ac_o       = ac_q;
  assign pc_o       = pc_q;
  assign dm_addr_o  = field;
  assign dm_wdata_o = ac_q;
  assign dm_we_o    = core_we;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (pc_q == '0 && ac_q == '0 && !dm_we_o));

  // R3
  add_result_chk: assert property (@(posedge clk) disable iff (!run_q)
    (op == OP_ADD) |=> (ac_q == DATA_W'($past(ac_q) + $past(r_q))));

  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (!run_q)
    dm_we_o |-> (op == OP_STAC));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!run_q)
    (op == OP_JUMP) |=> (pc_q == $past(field)));

  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (!run_q)
    (op inside {OP_NOP, OP_STAC, OP_MVAC, OP_JUMP, OP_JMPZ, OP_JMPNZ}) |=> $stable(z_q));

  // R9
  seq_pc_chk: assert property (@(posedge clk) disable iff (!run_q)
    !(op inside {OP_JUMP, OP_JMPZ, OP_JMPNZ}) |=> (pc_q == ADDR_W'($past(pc_q) + 1)));

endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_en;
  logic       load_imem;
  logic [3:0] load_addr;
  logic [7:0] load_data;
  logic [7:0] ac_o;
  logic [3:0] pc_o;
  logic [3:0] dm_addr_o;
  logic [7:0] dm_wdata_o;
  logic       dm_we_o;

  always #2.5 clk = ~clk;

  acc_cpu dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_imem  (load_imem),
    .load_addr  (load_addr),
    .load_data  (load_data),
    .ac_o       (ac_o),
    .pc_o       (pc_o),
    .dm_addr_o  (dm_addr_o),
    .dm_wdata_o (dm_wdata_o),
    .dm_we_o    (dm_we_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference state (behavioural).
  int prog_m [16];
  int data_m [16];
  int m_pc, m_ac, m_r, m_z;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // R2 field layout: code in the upper nibble, address in the lower.
  function automatic string tag_of(input int code);
    case (code)
      0:                  return "R10";
      1:                  return "R5/R11";
      2:                  return "R5";
      3, 4:               return "R6";
      5:                  return "R7";
      6, 7:               return "R7/R8";
      8, 9, 12, 13, 14:   return "R3";
      default:            return "R4";
    endcase
  endfunction

  task automatic step_model();
    int code, fld, npc;
    bit wr;
    code = prog_m[m_pc] >> 4;
    fld  = prog_m[m_pc] & 15;
    npc  = (m_pc + 1) % 16;
    wr   = 1'b0;
    case (code)
      1:  begin m_ac = data_m[fld]; wr = 1; end
      2:  data_m[fld] = m_ac;
      3:  m_r = m_ac;
      4:  begin m_ac = m_r; wr = 1; end
      5:  npc = fld;
      6:  if (m_z == 1) npc = fld;
      7:  if (m_z == 0) npc = fld;
      8:  begin m_ac = (m_ac + m_r) & 255; wr = 1; end
      9:  begin m_ac = (m_ac - m_r + 256) & 255; wr = 1; end
      10: begin m_ac = (m_ac + 1) & 255; wr = 1; end
      11: begin m_ac = 0; wr = 1; end
      12: begin m_ac = m_ac & m_r; wr = 1; end
      13: begin m_ac = m_ac | m_r; wr = 1; end
      14: begin m_ac = m_ac ^ m_r; wr = 1; end
      15: begin m_ac = (~m_ac) & 255; wr = 1; end
      default: ;
    endcase
    if (wr) m_z = (m_ac == 0) ? 1 : 0;
    m_pc = npc;
  endtask

  // Load both memories under reset, release, then compare every clock.
  task automatic run_prog(input int cycles, input int tag_pc, input int exp_addr,
                          input int exp_data, input string tag_req);
    string t;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", int'(pc_o), 0);
    check("R1", "ac in reset", int'(ac_o), 0);
    check("R1", "we in reset", int'(dm_we_o), 0);
    for (int i = 0; i < 32; i++) begin
      load_en   = 1'b1;
      load_imem = (i < 16);
      load_addr = 4'(i % 16);
      load_data = 8'((i < 16) ? prog_m[i] : data_m[i - 16]);
      @(negedge clk);
    end
    load_en = 1'b0;
    rst_n   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "we during release", int'(dm_we_o), 0);
    check("R1", "pc during release", int'(pc_o), 0);
    @(posedge clk);
    @(negedge clk);
    m_pc = 0; m_ac = 0; m_r = 0; m_z = 0;
    t = "R1";
    for (int c = 0; c < cycles; c++) begin
      int code;
      code = prog_m[m_pc] >> 4;
      check(t, "pc", int'(pc_o), m_pc);
      check(t, "ac", int'(ac_o), m_ac);
      check(tag_of(code), "store strobe", int'(dm_we_o), (code == 2) ? 1 : 0);
      if (code == 2) begin
        check("R5", "store address", int'(dm_addr_o), prog_m[m_pc] & 15);
        check("R5", "store data", int'(dm_wdata_o), m_ac);
      end
      if (m_pc == tag_pc && code == 2) begin
        check(tag_req, "target address", int'(dm_addr_o), exp_addr);
        check(tag_req, "target data", int'(dm_wdata_o), exp_data);
      end
      t = tag_of(code);
      if (code == 5 || code == 6 || code == 7 || code == 10 && m_ac == 255) t = {t, "/R9"};
      @(posedge clk);
      step_model();
      @(negedge clk);
    end
  endtask

  task automatic clear_images();
    for (int i = 0; i < 16; i++) begin
      prog_m[i] = 0;
      data_m[i] = 0;
    end
  endtask

  initial begin
    rst_n = 1'b0; load_en = 1'b0; load_imem = 1'b0; load_addr = '0; load_data = '0;
    repeat (3) @(posedge clk);

    // Program 1: loop ends when data byte 0 is 55; R12 store 2 <- 114.
    clear_images();
    prog_m[0] = 8'h10; prog_m[1] = 8'hA0; prog_m[2] = 8'h74; prog_m[3] = 8'h50;
    prog_m[4] = 8'hA0; prog_m[5] = 8'h30; prog_m[6] = 8'h80; prog_m[7] = 8'h22;
    prog_m[8] = 8'h00;
    data_m[0] = 55;
    run_prog(40, 7, 2, 114, "R12");

    // Program 2: CLAC INAC MVAC NOT XOR, untaken JMPZ, store 4 <- FF (R4, R8).
    clear_images();
    prog_m[0] = 8'hB0; prog_m[1] = 8'hA0; prog_m[2] = 8'h30; prog_m[3] = 8'hF0;
    prog_m[4] = 8'hE0; prog_m[5] = 8'h6A; prog_m[6] = 8'h24; prog_m[7] = 8'h00;
    prog_m[8] = 8'h00;
    run_prog(24, 6, 4, 255, "R4/R8");

    // Program 3: INAC wrap into taken JMPZ, SUB borrow, AND/OR/XOR to zero,
    // untaken JMPNZ, MOVR, store, CLAC, SUB wrap, PC wrap 15 -> 0 (R9).
    clear_images();
    prog_m[0]  = 8'h10; prog_m[1]  = 8'hA0; prog_m[2]  = 8'h64; prog_m[3]  = 8'h00;
    prog_m[4]  = 8'h11; prog_m[5]  = 8'h30; prog_m[6]  = 8'h12; prog_m[7]  = 8'h90;
    prog_m[8]  = 8'hC0; prog_m[9]  = 8'hD0; prog_m[10] = 8'hE0; prog_m[11] = 8'h70;
    prog_m[12] = 8'h40; prog_m[13] = 8'h25; prog_m[14] = 8'hB0; prog_m[15] = 8'h90;
    data_m[0] = 255; data_m[1] = 8'h0F; data_m[2] = 8'h3C;
    run_prog(48, 13, 5, 8'h0F, "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule